// File: doc/BRIEF.md
# Programmable Display Video Timing Generator

This block produces horizontal sync, vertical sync, a data-enable strobe and pixel data for one display pixel stream. A host writes its timing words over a simple register bus. Horizontal positions come from a pixel counter inside each line. Vertical positions do not use line numbers. They are measured by one counter that runs across the whole frame in pixel clocks. Every vertical setting (frame length, vsync width, window edges) is therefore programmed as a pixel-clock offset from the start of the frame, and any hsync skew is already folded into those values.

An optional inner active window can be enabled separately in each axis. Pixels that lie inside the display window but outside the active window carry a programmed border colour. Inside the active window the block passes upstream pixels through, and it substitutes an underflow colour when upstream has no valid pixel. Each sync output and the data-enable output has its own polarity bit. A one-cycle fetch pulse can be placed at any frame position. Free-running frame and line counters can be read back over the bus. While the engine runs, new settings are held in shadow storage and reach the live timing only at a frame boundary.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset and whenever the engine is disabled (word 0, bit 0 clear), hsync, vsync and de sit at their polarity bits, pix_data and fetch_pulse are 0, and a read of the frame count (word 16) or line count (word 17) returns 0.
- R2: Word 2 holds the line period in pixels in bits 31:16 and the hsync width in bits 15:0. Raw hsync is high for the first width pixels of every line, and every frame starts at pixel 0 of a line.
- R3: Frame position runs from 0 to (word 3) − 1 and then wraps. Raw vsync is high while skew (word 13) ≤ position < skew + vsync width (word 4).
- R4: Raw de is high when the frame position lies in [word 5, word 6] inclusive and the line pixel lies in [word 7 bits 15:0, word 7 bits 31:16] inclusive.
- R5: With word 1 bit 29 set, pixels whose line position lies outside [word 8 bits 15:0, word 8 bits 31:16] carry the border colour (word 11). With word 1 bit 30 set, pixels whose frame position lies outside [word 9, word 10] also carry the border colour. These rules apply only inside the display window.
- R6: Inside both windows, pix_data is up_data when up_valid is high and the underflow colour (word 12) otherwise. Outside the display window pix_data is 0.
- R7: Word 14 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R8: With word 1 bit 31 set, fetch_pulse is high for exactly the pixel whose frame position equals word 15. With that bit clear it never rises.
- R9: The line counter clears and the frame counter increments when the frame position equals the skew. Apart from that, the line counter increments on the last pixel of each line.
- R10: While the engine is enabled, writes to words 1–15 take effect only from the first pixel of the next frame.
- R11: A read returns the last value written to a configuration word one clock after reg_rd. The output for frame position n appears on the (n+1)-th rising edge after the edge that captures the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| up_data | input | COLOR_W | Upstream pixel |
| up_valid | input | 1 | Upstream pixel is valid |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_data | output | COLOR_W | Pixel output |
| fetch_pulse | output | 1 | Programmed early-fetch pulse |

## Verification
The bench sweeps every pixel of two full frames under three geometries. These cover a zero skew, a skew that pushes vsync into the middle of a line, and a skew that lands on a late pixel. A design that took skew out of the sync edges rather than treating it as an offset, or that left the line pixel counting across a frame wrap, would shift every vsync and de edge in those runs. One run rewrites the border colour early in a frame with an inner window active. If the design applied writes at once, the new colour would show up mid-frame. Other checks cover a disabled fetch position, inverted polarities, and frame and line counts taken at a known pixel. These catch counters that reset at the frame wrap instead of at the vsync start, and counters that go on reading nonzero after the engine stops.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // word indices on the register bus
    localparam int A_ENABLE    = 0;
    localparam int A_CTRL      = 1;
    localparam int A_HCTL      = 2;
    localparam int A_VPERIOD   = 3;
    localparam int A_VPULSE    = 4;
    localparam int A_DVSTART   = 5;
    localparam int A_DVEND     = 6;
    localparam int A_DHCTL     = 7;
    localparam int A_AHCTL     = 8;
    localparam int A_AVSTART   = 9;
    localparam int A_AVEND     = 10;
    localparam int A_BORDER    = 11;
    localparam int A_UNDERFLOW = 12;
    localparam int A_SKEW      = 13;
    localparam int A_POLARITY  = 14;
    localparam int A_FETCH     = 15;
    localparam int A_FRAMECNT  = 16;
    localparam int A_LINECNT   = 17;

    localparam int CTRL_AH_BIT    = 29;
    localparam int CTRL_AV_BIT    = 30;
    localparam int CTRL_FETCH_BIT = 31;

    typedef struct packed {
        word_t ctrl;
        word_t hctl;
        word_t vperiod;
        word_t vpulse;
        word_t dvstart;
        word_t dvend;
        word_t dhctl;
        word_t ahctl;
        word_t avstart;
        word_t avend;
        word_t border;
        word_t underflow;
        word_t skew;
        word_t polarity;
        word_t fetch;
    } cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LINE_W = 16,
    parameter int FCNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  word_t             reg_wdata,
    input  logic              frame_wrap,
    input  logic [FCNT_W-1:0] frame_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    output logic              en,
    output cfg_t              live,
    output word_t             reg_rdata
);
    typedef struct packed {
        logic  en;
        cfg_t  shadow;
        cfg_t  live;
        word_t rdata;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (int'(reg_addr))
                A_ENABLE:    st_d.en               = reg_wdata[0];
                A_CTRL:      st_d.shadow.ctrl      = reg_wdata;
                A_HCTL:      st_d.shadow.hctl      = reg_wdata;
                A_VPERIOD:   st_d.shadow.vperiod   = reg_wdata;
                A_VPULSE:    st_d.shadow.vpulse    = reg_wdata;
                A_DVSTART:   st_d.shadow.dvstart   = reg_wdata;
                A_DVEND:     st_d.shadow.dvend     = reg_wdata;
                A_DHCTL:     st_d.shadow.dhctl     = reg_wdata;
                A_AHCTL:     st_d.shadow.ahctl     = reg_wdata;
                A_AVSTART:   st_d.shadow.avstart   = reg_wdata;
                A_AVEND:     st_d.shadow.avend     = reg_wdata;
                A_BORDER:    st_d.shadow.border    = reg_wdata;
                A_UNDERFLOW: st_d.shadow.underflow = reg_wdata;
                A_SKEW:      st_d.shadow.skew      = reg_wdata;
                A_POLARITY:  st_d.shadow.polarity  = reg_wdata;
                A_FETCH:     st_d.shadow.fetch     = reg_wdata;
                default: ;
            endcase
        end
        // live timing follows shadow while idle, else only at frame wrap
        if (!st_q.en || frame_wrap) st_d.live = st_q.shadow;
        if (reg_rd) begin
            case (int'(reg_addr))
                A_ENABLE:    st_d.rdata = word_t'(st_q.en);
                A_CTRL:      st_d.rdata = st_q.shadow.ctrl;
                A_HCTL:      st_d.rdata = st_q.shadow.hctl;
                A_VPERIOD:   st_d.rdata = st_q.shadow.vperiod;
                A_VPULSE:    st_d.rdata = st_q.shadow.vpulse;
                A_DVSTART:   st_d.rdata = st_q.shadow.dvstart;
                A_DVEND:     st_d.rdata = st_q.shadow.dvend;
                A_DHCTL:     st_d.rdata = st_q.shadow.dhctl;
                A_AHCTL:     st_d.rdata = st_q.shadow.ahctl;
                A_AVSTART:   st_d.rdata = st_q.shadow.avstart;
                A_AVEND:     st_d.rdata = st_q.shadow.avend;
                A_BORDER:    st_d.rdata = st_q.shadow.border;
                A_UNDERFLOW: st_d.rdata = st_q.shadow.underflow;
                A_SKEW:      st_d.rdata = st_q.shadow.skew;
                A_POLARITY:  st_d.rdata = st_q.shadow.polarity;
                A_FETCH:     st_d.rdata = st_q.shadow.fetch;
                A_FRAMECNT:  st_d.rdata = st_q.en ? word_t'(frame_cnt) : '0;
                A_LINECNT:   st_d.rdata = st_q.en ? word_t'(line_cnt) : '0;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en        = st_q.en;
    assign live      = st_q.live;
    assign reg_rdata = st_q.rdata;

    // R10
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !frame_wrap) |=> $stable(st_q.live));
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
    parameter int POS_W  = 24,
    parameter int HPOS_W = 16,
    parameter int LINE_W = 16,
    parameter int FCNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HPOS_W-1:0] h_period,
    input  logic [POS_W-1:0]  v_period,
    input  logic [POS_W-1:0]  skew,
    output logic [HPOS_W-1:0] h_pos,
    output logic [POS_W-1:0]  f_pos,
    output logic              frame_wrap,
    output logic [LINE_W-1:0] line_cnt,
    output logic [FCNT_W-1:0] frame_cnt
);
    typedef struct packed {
        logic [HPOS_W-1:0] h;
        logic [POS_W-1:0]  f;
        logic [LINE_W-1:0] line;
        logic [FCNT_W-1:0] frame;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic h_last, f_last, vs_start;

    always_comb begin
        h_last   = (cnt_q.h == h_period - 1'b1);
        f_last   = (cnt_q.f == v_period - 1'b1);
        vs_start = (cnt_q.f == skew);
        cnt_d    = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else begin
            cnt_d.h = (h_last || f_last) ? '0 : cnt_q.h + 1'b1;
            cnt_d.f = f_last ? '0 : cnt_q.f + 1'b1;
            if (vs_start) begin
                cnt_d.line  = '0;
                cnt_d.frame = cnt_q.frame + 1'b1;
            end else if (h_last) begin
                cnt_d.line = cnt_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign h_pos      = cnt_q.h;
    assign f_pos      = cnt_q.f;
    assign frame_wrap = en && f_last;
    assign line_cnt   = cnt_q.line;
    assign frame_cnt  = cnt_q.frame;

    // R1
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q.f == '0 && cnt_q.h == '0));
    // R3
    f_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && v_period != '0 && $stable(v_period)) |-> (cnt_q.f < v_period));
    // R9
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q.f == skew) |=> (cnt_q.line == '0));
endmodule

// File: rtl/dtg_output.sv
module dtg_output
    import dtg_pkg::*;
#(
    parameter int POS_W   = 24,
    parameter int HPOS_W  = 16,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  cfg_t               cfg,
    input  logic [HPOS_W-1:0]  h_pos,
    input  logic [POS_W-1:0]   f_pos,
    input  logic [COLOR_W-1:0] up_data,
    input  logic               up_valid,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [COLOR_W-1:0] pix_data,
    output logic               fetch_pulse
);
    typedef struct packed {
        logic               hs;
        logic               vs;
        logic               de;
        logic               de_raw;
        logic [COLOR_W-1:0] pix;
        logic               fetch;
    } out_t;

    out_t out_d, out_q;
    logic [POS_W:0] vs_end;
    logic hs_raw, vs_raw, disp, act_h, act_v;

    always_comb begin
        vs_end = {1'b0, cfg.skew[POS_W-1:0]} + {1'b0, cfg.vpulse[POS_W-1:0]};
        hs_raw = en && (h_pos < cfg.hctl[HPOS_W-1:0]);
        vs_raw = en && (f_pos >= cfg.skew[POS_W-1:0]) && ({1'b0, f_pos} < vs_end);
        disp   = en && (f_pos >= cfg.dvstart[POS_W-1:0]) && (f_pos <= cfg.dvend[POS_W-1:0])
                    && (h_pos >= cfg.dhctl[HPOS_W-1:0]) && (h_pos <= cfg.dhctl[16+:HPOS_W]);
        act_h  = !cfg.ctrl[CTRL_AH_BIT]
                 || ((h_pos >= cfg.ahctl[HPOS_W-1:0]) && (h_pos <= cfg.ahctl[16+:HPOS_W]));
        act_v  = !cfg.ctrl[CTRL_AV_BIT]
                 || ((f_pos >= cfg.avstart[POS_W-1:0]) && (f_pos <= cfg.avend[POS_W-1:0]));

        out_d.hs     = hs_raw ^ cfg.polarity[0];
        out_d.vs     = vs_raw ^ cfg.polarity[1];
        out_d.de     = disp ^ cfg.polarity[2];
        out_d.de_raw = disp;
        if (!disp)                out_d.pix = '0;
        else if (!(act_h && act_v)) out_d.pix = cfg.border[COLOR_W-1:0];
        else if (up_valid)        out_d.pix = up_data;
        else                      out_d.pix = cfg.underflow[COLOR_W-1:0];
        out_d.fetch = en && cfg.ctrl[CTRL_FETCH_BIT] && (f_pos == cfg.fetch[POS_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hsync       = out_q.hs;
    assign vsync       = out_q.vs;
    assign de          = out_q.de;
    assign pix_data    = out_q.pix;
    assign fetch_pulse = out_q.fetch;

    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_q.pix == '0 && !out_q.fetch));
    // R7
    idle_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_q.hs == $past(cfg.polarity[0]) && out_q.vs == $past(cfg.polarity[1])));
    // R4
    de_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q.de_raw) |-> $past(en));
    // R8
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q.fetch) |-> $past(cfg.ctrl[CTRL_FETCH_BIT]));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int POS_W   = 24,
    parameter int HPOS_W  = 16,
    parameter int LINE_W  = 16,
    parameter int FCNT_W  = 32,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [COLOR_W-1:0] up_data,
    input  logic               up_valid,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [COLOR_W-1:0] pix_data,
    output logic               fetch_pulse
);
    logic              en;
    cfg_t              live;
    logic              frame_wrap;
    logic [HPOS_W-1:0] h_pos;
    logic [POS_W-1:0]  f_pos;
    logic [LINE_W-1:0] line_cnt;
    logic [FCNT_W-1:0] frame_cnt;

    dtg_regs #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .FCNT_W(FCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frame_wrap(frame_wrap),
        .frame_cnt(frame_cnt), .line_cnt(line_cnt), .en(en), .live(live),
        .reg_rdata(reg_rdata)
    );

    dtg_counters #(.POS_W(POS_W), .HPOS_W(HPOS_W), .LINE_W(LINE_W), .FCNT_W(FCNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en),
        .h_period(live.hctl[16+:HPOS_W]), .v_period(live.vperiod[POS_W-1:0]),
        .skew(live.skew[POS_W-1:0]), .h_pos(h_pos), .f_pos(f_pos),
        .frame_wrap(frame_wrap), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
    );

    dtg_output #(.POS_W(POS_W), .HPOS_W(HPOS_W), .COLOR_W(COLOR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(live), .h_pos(h_pos), .f_pos(f_pos),
        .up_data(up_data), .up_valid(up_valid), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_data(pix_data), .fetch_pulse(fetch_pulse)
    );
endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] up_data = '0;
    logic        up_valid = 1'b0;
    logic        hsync, vsync, de, fetch_pulse;
    logic [23:0] pix_data;

    int tests = 0, fails = 0;
    bit done = 0;

    int hsw, hbp, wd, hfp, vsw, vbp, ht, vfp, skew;
    int hper, vper, vpul, dvs, dve, dhs, dhe, ahs, ahe, avs, ave;
    int fetchp, wp;
    logic [31:0] ctrl, pol, border, border_new, under;

    always #10 clk = ~clk;

    disp_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .up_data(up_data), .up_valid(up_valid), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_data(pix_data), .fetch_pulse(fetch_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        reg_rd = 1'b1; reg_addr = 5'(addr);
        @(negedge clk);
        data = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [23:0] up_of(input int q);
        return 24'(q * 3 + 1);
    endfunction

    function automatic bit valid_of(input int q);
        return (q % 5) != 2;
    endfunction

    task automatic program_cfg();
        hper = hsw + hbp + wd + hfp;
        vper = (vsw + vbp + ht + vfp) * hper;
        vpul = vsw * hper;
        dvs  = (vsw + vbp) * hper + skew;
        dve  = (vsw + vbp + ht) * hper + skew - 1;
        dhs  = hbp + hsw;
        dhe  = hper - hfp - 1;
        wr(1, ctrl);
        wr(2, (hper << 16) | hsw);
        wr(3, vper);
        wr(4, vpul);
        wr(5, dvs);
        wr(6, dve);
        wr(7, (dhe << 16) | dhs);
        wr(8, (ahe << 16) | ahs);
        wr(9, avs);
        wr(10, ave);
        wr(11, border);
        wr(12, under);
        wr(13, skew);
        wr(14, pol);
        wr(15, fetchp);
    endtask

    task automatic run_cfg(input string name);
        logic [31:0] v;
        int n, mframe, mline;
        program_cfg();
        // R11 readback of a staged word
        rd(7, v);
        chk({"R11 readback ", name}, v, (dhe << 16) | dhs);
        n = 2 * vper;
        mframe = 0; mline = 0;
        wr(0, 1);
        up_data = up_of(0); up_valid = valid_of(0);
        for (int q = 0; q < n; q++) begin
            int f, h;
            bit ehs, evs, ede, efe, ah, av;
            logic [23:0] epx, bc;
            @(negedge clk);
            reg_wr = 1'b0;
            f = q % vper; h = f % hper;
            ehs = h < hsw;
            evs = (f >= skew) && (f < skew + vpul);
            ede = (f >= dvs) && (f <= dve) && (h >= dhs) && (h <= dhe);
            ah  = !ctrl[29] || ((h >= ahs) && (h <= ahe));
            av  = !ctrl[30] || ((f >= avs) && (f <= ave));
            bc  = (wp >= 0 && q >= vper) ? border_new[23:0] : border[23:0];
            if (!ede) epx = '0;
            else if (!(ah && av)) epx = bc;
            else if (valid_of(q)) epx = up_of(q);
            else epx = under[23:0];
            efe = ctrl[31] && (f == fetchp);
            chk({"R2 R7 hsync ", name}, 32'(hsync), 32'(ehs ^ pol[0]));
            chk({"R3 R7 vsync ", name}, 32'(vsync), 32'(evs ^ pol[1]));
            chk({"R4 R7 de ", name}, 32'(de), 32'(ede ^ pol[2]));
            chk({"R5 R6 R10 pix ", name}, 32'(pix_data), 32'(epx));
            chk({"R8 fetch ", name}, 32'(fetch_pulse), 32'(efe));
            if (f == skew) begin mline = 0; mframe++; end
            else if (h == hper - 1) mline++;
            up_data = up_of(q + 1); up_valid = valid_of(q + 1);
            if (q == wp) begin
                reg_wr = 1'b1; reg_addr = 5'd11; reg_wdata = border_new;
            end
        end
        // R9 counters at known positions
        rd(16, v);
        chk({"R9 frame count ", name}, v, 32'(mframe));
        begin
            int f, h;
            f = n % vper; h = f % hper;
            if (f == skew) mline = 0;
            else if (h == hper - 1) mline++;
        end
        rd(17, v);
        chk({"R9 line count ", name}, v, 32'(mline));
        wr(0, 0);
        @(negedge clk);
        // R1 idle state after disable
        chk({"R1 idle syncs ", name}, {29'b0, de, vsync, hsync}, pol & 32'h7);
        chk({"R1 idle pix ", name}, 32'(pix_data), 32'h0);
        rd(16, v);
        chk({"R1 frame count zero ", name}, v, 32'h0);
        if (wp >= 0) begin
            rd(11, v);
            chk({"R11 border readback ", name}, v, border_new);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset syncs", {28'b0, fetch_pulse, de, vsync, hsync}, 32'h0);
        chk("R1 reset pix", 32'(pix_data), 32'h0);
        rd(0, v);
        chk("R1 reset enable", v, 32'h0);
        rd(17, v);
        chk("R1 reset line count", v, 32'h0);

        // config A: zero skew, fetch on, no inner window
        hsw = 2; hbp = 2; wd = 4; hfp = 2; vsw = 1; vbp = 1; ht = 3; vfp = 1; skew = 0;
        ahs = 0; ahe = 0; avs = 0; ave = 0;
        ctrl = 32'h8000_0000; pol = 0; fetchp = 5; wp = -1;
        border = 32'h00AA55; border_new = 32'h0; under = 32'h123456;
        run_cfg("cfgA");

        // config B: skew 3, both inner windows, inverted outputs, staged border write
        skew = 3; ahs = 5; ahe = 6; avs = 30; ave = 39;
        ctrl = 32'hE000_0000; pol = 7; fetchp = 5; wp = 10;
        border = 32'h00F00F; border_new = 32'h0C0C0C; under = 32'h654321;
        run_cfg("cfgB");

        // config C: other geometry, horizontal window only, fetch off
        hsw = 1; hbp = 3; wd = 3; hfp = 1; vsw = 2; vbp = 1; ht = 2; vfp = 2; skew = 5;
        ahs = 4; ahe = 5; avs = 0; ave = 0;
        ctrl = 32'h2000_0000; pol = 2; fetchp = 3; wp = -1;
        border = 32'h777777; border_new = 32'h0; under = 32'h0000FF;
        run_cfg("cfgC");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule